// File: doc/BRIEF.md
# SDRAM Bank-Interleaving Page Controller

This block sits between a memory request source and an SDRAM command path. It tracks the row open in every internal bank of every chip select and chooses the command sequence for each access. Each request carries a flat word address, a chip-select index and a read/write flag. The block splits the address into bank, row and column fields under one of two mapping modes. It then emits ACTIVATE, PRECHARGE, READ and WRITE commands on a one-command-per-cycle port. The row goes out on the device address lines during ACTIVATE and the column goes out on the same lines during READ/WRITE. The bank goes out on its own bank-select lines.

When an access misses and the target bank is not the one holding the open page, the controller activates the new row first and closes the old row in the next cycle. The old row's precharge time then overlaps the new row's activate-to-column delay. Overlap between two banks of the same device can be disabled by a configuration bit. Overlap between two different chip selects is always used. A miss inside the bank that already holds the open row always goes precharge, then wait, then activate.

Legal configuration: `cfg_col_bits` from 6 to 8, `cfg_trcd` from 2 to 15, `cfg_trp` from 1 to 15. Configuration changes only while `busy` is low. Request fields are held stable while `req_valid` is high and until `req_ready` is seen.

Top module: `sdram_page_ctrl`

## Requirements
- R1: During and after reset, no command is issued (`cmd_op` = 0, `cmd_valid` low), `busy` and `req_ready` are low and every bank is closed, so the first access after reset starts with ACTIVATE.
- R2: With `cfg_page_map` = 1 (page-based), the column is address bits [c-1:0], the bank is bits [c+1:c] and the row is the 12 bits from bit c+2 upward, where c = `cfg_col_bits`. Consecutive pages therefore land in consecutive banks.
- R3: With `cfg_page_map` = 0 (bank-based), the bank is the two most significant address bits [21:20], the column is bits [c-1:0] and the row is the 12 bits from bit c upward. Crossing a page boundary inside a bank keeps the same bank.
- R4: A request whose target bank holds the same row gets READ (`cmd_op` = 3) or WRITE (`cmd_op` = 4) as its first command, in the cycle after it is accepted.
- R5: A request to a bank that holds a different row gets PRECHARGE (`cmd_op` = 2) of that bank, then ACTIVATE (`cmd_op` = 1) `cfg_trp` cycles later, then the column command `cfg_trcd` cycles after the ACTIVATE.
- R6: A request to a closed bank, while a row is open in another bank, gets ACTIVATE of the new row first, PRECHARGE of the old bank in the next cycle, and the column command `cfg_trcd` cycles after the ACTIVATE. This applies when `cfg_no_ibank_ilv` = 0, or when the two banks are on different chip selects.
- R7: With `cfg_no_ibank_ilv` = 1 and the open row on another bank of the same chip select, the old bank is precharged first, ACTIVATE follows `cfg_trp` cycles later, and the column command follows `cfg_trcd` cycles after that.
- R8: With `cfg_no_ibank_ilv` = 1, a request to a different chip select still uses the overlapped sequence of R6.
- R9: A request when no row is open anywhere gets ACTIVATE, then the column command `cfg_trcd` cycles later.
- R10: `req_ready` is high for exactly one cycle per request, the same cycle as its column command. `busy` is high from the first command cycle through that cycle and low in the next cycle. No second request starts while `busy` is high.
- R11: `dev_bank` and `cmd_cs` carry the bank and chip select of every command. `dev_addr` carries the row on ACTIVATE and the column on READ/WRITE, and is zero on PRECHARGE and on idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_page_map | input | 1 | 1 = page-based bank mapping, 0 = bank-based |
| cfg_no_ibank_ilv | input | 1 | 1 = no overlap between banks of one chip select |
| cfg_col_bits | input | 4 | Number of column address bits |
| cfg_trcd | input | 4 | Activate-to-column delay in cycles |
| cfg_trp | input | 4 | Precharge-to-activate delay in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completed (column command issued) |
| req_addr | input | 22 | Flat word address |
| req_cs | input | 1 | Chip-select index |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | Command sequence in progress |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 3 | 0 none, 1 ACTIVATE, 2 PRECHARGE, 3 READ, 4 WRITE |
| cmd_cs | output | 1 | Chip-select index of the command |
| dev_bank | output | 2 | Bank-select lines |
| dev_addr | output | 12 | Multiplexed row/column address |

## Verification
A wrong entry in the open-row table, or a stale record of which page is open, shows up at the first command of the next request that touches that bank. The port then carries the wrong kind of command, for example ACTIVATE where READ is due or PRECHARGE of the wrong bank, one cycle after acceptance. A wrong delay count shifts the ACTIVATE or the column command, and `req_ready`, by one or more cycles inside the same request. Comparing every port on every cycle against a behavioural model catches both kinds of error within a few cycles of the faulty step.

// File: rtl/sdpc_pkg.sv
// Package: shared command and sequencer encodings for the SDRAM page controller.
// Assumes: the command codes are visible at the top-level cmd_op port.
package sdpc_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_PRE = 3'd2,
        OP_RD  = 3'd3,
        OP_WR  = 3'd4
    } sdpc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ACT,
        ST_PRE_OLD,
        ST_WAIT_COL,
        ST_DONE
    } sdpc_state_e;

endpackage

// File: rtl/sdpc_addr_map.sv
// Module: splits a flat word address into bank, row and column fields.
// Page mode takes the bank from the bits just above the column.
// Bank mode takes it from the top address bits.
// Assumes: col_bits + BANK_W + ROW_W <= ADDR_W in page mode and
//          col_bits + ROW_W <= ADDR_W - BANK_W in bank mode.
module sdpc_addr_map #(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int CB_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              page_map,
    input  logic [CB_W-1:0]   col_bits,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [ROW_W-1:0]  col
);

    logic [ADDR_W-1:0] col_mask;
    logic [ADDR_W-1:0] col_full;
    logic [ADDR_W-1:0] above_col;
    logic [ADDR_W-1:0] row_full;

    // Column field: the address bits below the programmed column width.
    assign col_mask  = ~({ADDR_W{1'b1}} << col_bits);
    assign col_full  = addr & col_mask;
    assign above_col = addr >> col_bits;
    assign col       = col_full[ROW_W-1:0];

    // Bank and row field selection for the two mapping modes.
    always_comb begin
        if (page_map) begin
            bank     = above_col[BANK_W-1:0];
            row_full = above_col >> BANK_W;
        end else begin
            bank     = addr[ADDR_W-1 -: BANK_W];
            row_full = above_col;
        end
    end

    assign row = row_full[ROW_W-1:0];

endmodule

// File: rtl/sdpc_open_table.sv
// Module: one open-row register and valid flag per bank per chip select.
// There is one lookup port, one set port and one clear port.
// Assumes: set and clear never address the same entry in the same cycle.
module sdpc_open_table #(
    parameter int CS_W   = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CS_W-1:0]   lk_cs,
    input  logic [BANK_W-1:0] lk_bank,
    output logic              lk_valid,
    output logic [ROW_W-1:0]  lk_row,
    input  logic              set_en,
    input  logic [CS_W-1:0]   set_cs,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [CS_W-1:0]   clr_cs,
    input  logic [BANK_W-1:0] clr_bank
);

    localparam int IDX_W   = CS_W + BANK_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] vld;
    logic [ROW_W-1:0]   rows [ENTRIES];
    logic [IDX_W-1:0]   set_idx;
    logic [IDX_W-1:0]   clr_idx;
    logic [IDX_W-1:0]   lk_idx;

    assign set_idx = {set_cs, set_bank};
    assign clr_idx = {clr_cs, clr_bank};
    assign lk_idx  = {lk_cs, lk_bank};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Entry state: opened by ACTIVATE, closed by PRECHARGE.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]  <= 1'b0;
                rows[g] <= '0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                vld[g]  <= 1'b1;
                rows[g] <= set_row;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                vld[g]  <= 1'b0;
            end
        end
    end

    // Lookup of the requested bank.
    assign lk_valid = vld[lk_idx];
    assign lk_row   = rows[lk_idx];

endmodule

// File: rtl/sdpc_seq.sv
// Module: command sequencer. It classifies a request as hit, same-bank miss,
// overlapped miss, serial miss or cold activate, and steps through the
// commands with a down-counter for the ACT->column and PRE->ACT delays.
// All command outputs are registered.
// Assumes: trcd >= 2, trp >= 1, request fields stable until req_ready.
module sdpc_seq
    import sdpc_pkg::*;
#(
    parameter int CS_W   = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_no_ibank_ilv,
    input  logic [TIM_W-1:0]  cfg_trcd,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] map_bank,
    input  logic [ROW_W-1:0]  map_row,
    input  logic [ROW_W-1:0]  map_col,
    input  logic              lk_valid,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              set_en,
    output logic [CS_W-1:0]   set_cs,
    output logic [BANK_W-1:0] set_bank,
    output logic [ROW_W-1:0]  set_row,
    output logic              clr_en,
    output logic [CS_W-1:0]   clr_cs,
    output logic [BANK_W-1:0] clr_bank,
    output sdpc_op_e          cmd_op,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              busy,
    output logic              req_ready
);

    sdpc_state_e       state, nxt_state;
    logic [TIM_W-1:0]  cnt, nxt_cnt;
    logic [CS_W-1:0]   tgt_cs, prev_cs, cur_cs;
    logic [BANK_W-1:0] tgt_bank, prev_bank, cur_bank;
    logic [ROW_W-1:0]  tgt_row, tgt_col;
    logic              tgt_wr, cur_valid;
    logic              load_tgt;
    sdpc_op_e          iss_op;
    logic [CS_W-1:0]   iss_cs;
    logic [BANK_W-1:0] iss_bank;
    logic [ROW_W-1:0]  iss_addr;
    logic              ilv_ok;
    logic              row_hit;

    // Overlap is allowed across chip selects always, within one only if enabled.
    assign ilv_ok  = (cur_cs != req_cs) || !cfg_no_ibank_ilv;
    assign row_hit = lk_valid && (lk_row == map_row);

    // Next-state and command selection.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        load_tgt  = 1'b0;
        iss_op    = OP_NOP;
        iss_cs    = '0;
        iss_bank  = '0;
        iss_addr  = '0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    load_tgt = 1'b1;
                    if (row_hit) begin
                        iss_op    = req_write ? OP_WR : OP_RD;
                        iss_cs    = req_cs;
                        iss_bank  = map_bank;
                        iss_addr  = map_col;
                        nxt_state = ST_DONE;
                    end else if (lk_valid) begin
                        iss_op    = OP_PRE;
                        iss_cs    = req_cs;
                        iss_bank  = map_bank;
                        nxt_cnt   = cfg_trp - TIM_W'(1);
                        nxt_state = ST_WAIT_ACT;
                    end else if (cur_valid && ilv_ok) begin
                        iss_op    = OP_ACT;
                        iss_cs    = req_cs;
                        iss_bank  = map_bank;
                        iss_addr  = map_row;
                        nxt_state = ST_PRE_OLD;
                    end else if (cur_valid) begin
                        iss_op    = OP_PRE;
                        iss_cs    = cur_cs;
                        iss_bank  = cur_bank;
                        nxt_cnt   = cfg_trp - TIM_W'(1);
                        nxt_state = ST_WAIT_ACT;
                    end else begin
                        iss_op    = OP_ACT;
                        iss_cs    = req_cs;
                        iss_bank  = map_bank;
                        iss_addr  = map_row;
                        nxt_cnt   = cfg_trcd - TIM_W'(1);
                        nxt_state = ST_WAIT_COL;
                    end
                end
            end
            ST_WAIT_ACT: begin
                if (cnt == '0) begin
                    iss_op    = OP_ACT;
                    iss_cs    = tgt_cs;
                    iss_bank  = tgt_bank;
                    iss_addr  = tgt_row;
                    nxt_cnt   = cfg_trcd - TIM_W'(1);
                    nxt_state = ST_WAIT_COL;
                end else begin
                    nxt_cnt = cnt - TIM_W'(1);
                end
            end
            ST_PRE_OLD: begin
                iss_op    = OP_PRE;
                iss_cs    = prev_cs;
                iss_bank  = prev_bank;
                nxt_cnt   = cfg_trcd - TIM_W'(2);
                nxt_state = ST_WAIT_COL;
            end
            ST_WAIT_COL: begin
                if (cnt == '0) begin
                    iss_op    = tgt_wr ? OP_WR : OP_RD;
                    iss_cs    = tgt_cs;
                    iss_bank  = tgt_bank;
                    iss_addr  = tgt_col;
                    nxt_state = ST_DONE;
                end else begin
                    nxt_cnt = cnt - TIM_W'(1);
                end
            end
            ST_DONE: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Table update strobes follow the issued command.
    assign set_en   = (iss_op == OP_ACT);
    assign set_cs   = iss_cs;
    assign set_bank = iss_bank;
    assign set_row  = iss_addr;
    assign clr_en   = (iss_op == OP_PRE);
    assign clr_cs   = iss_cs;
    assign clr_bank = iss_bank;

    // Sequencer state and delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Latch the decoded target and the page open before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_cs    <= '0;
            tgt_bank  <= '0;
            tgt_row   <= '0;
            tgt_col   <= '0;
            tgt_wr    <= 1'b0;
            prev_cs   <= '0;
            prev_bank <= '0;
        end else if (load_tgt) begin
            tgt_cs    <= req_cs;
            tgt_bank  <= map_bank;
            tgt_row   <= map_row;
            tgt_col   <= map_col;
            tgt_wr    <= req_write;
            prev_cs   <= cur_cs;
            prev_bank <= cur_bank;
        end
    end

    // Track the most recently activated page as the current open page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_cs    <= '0;
            cur_bank  <= '0;
        end else if (iss_op == OP_ACT) begin
            cur_valid <= 1'b1;
            cur_cs    <= iss_cs;
            cur_bank  <= iss_bank;
        end else if (iss_op == OP_PRE && iss_cs == cur_cs && iss_bank == cur_bank) begin
            cur_valid <= 1'b0;
        end
    end

    // Registered command port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op   <= OP_NOP;
            cmd_cs   <= '0;
            cmd_bank <= '0;
            cmd_addr <= '0;
        end else begin
            cmd_op   <= iss_op;
            cmd_cs   <= iss_cs;
            cmd_bank <= iss_bank;
            cmd_addr <= iss_addr;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign req_ready = (state == ST_DONE);

endmodule

// File: rtl/sdram_page_ctrl.sv
// Module: top of the SDRAM bank-interleaving page controller. It joins the
// address mapper, the open-row table and the command sequencer.
// Assumes: configuration changes only while busy is low.
module sdram_page_ctrl
    import sdpc_pkg::*;
#(
    parameter  int ADDR_W = 22,
    parameter  int NUM_CS = 2,
    parameter  int BANK_W = 2,
    parameter  int ROW_W  = 12,
    parameter  int CB_W   = 4,
    parameter  int TIM_W  = 4,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_page_map,
    input  logic              cfg_no_ibank_ilv,
    input  logic [CB_W-1:0]   cfg_col_bits,
    input  logic [TIM_W-1:0]  cfg_trcd,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_write,
    output logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [BANK_W-1:0] dev_bank,
    output logic [ROW_W-1:0]  dev_addr
);

    logic [BANK_W-1:0] map_bank;
    logic [ROW_W-1:0]  map_row, map_col;
    logic              lk_valid;
    logic [ROW_W-1:0]  lk_row;
    logic              set_en, clr_en;
    logic [CS_W-1:0]   set_cs, clr_cs;
    logic [BANK_W-1:0] set_bank, clr_bank;
    logic [ROW_W-1:0]  set_row;
    sdpc_op_e          op_q;

    sdpc_addr_map #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .CB_W(CB_W)
    ) map_i (
        .addr(req_addr), .page_map(cfg_page_map), .col_bits(cfg_col_bits),
        .bank(map_bank), .row(map_row), .col(map_col)
    );

    sdpc_open_table #(
        .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .lk_cs(req_cs), .lk_bank(map_bank), .lk_valid(lk_valid), .lk_row(lk_row),
        .set_en(set_en), .set_cs(set_cs), .set_bank(set_bank), .set_row(set_row),
        .clr_en(clr_en), .clr_cs(clr_cs), .clr_bank(clr_bank)
    );

    sdpc_seq #(
        .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TIM_W(TIM_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_no_ibank_ilv(cfg_no_ibank_ilv), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .map_bank(map_bank), .map_row(map_row), .map_col(map_col),
        .lk_valid(lk_valid), .lk_row(lk_row),
        .set_en(set_en), .set_cs(set_cs), .set_bank(set_bank), .set_row(set_row),
        .clr_en(clr_en), .clr_cs(clr_cs), .clr_bank(clr_bank),
        .cmd_op(op_q), .cmd_cs(cmd_cs), .cmd_bank(dev_bank), .cmd_addr(dev_addr),
        .busy(busy), .req_ready(req_ready)
    );

    assign cmd_op    = op_q;
    assign cmd_valid = (op_q != OP_NOP);

endmodule

// File: rtl/sdram_page_ctrl_chk.sv
// Module: protocol checker for the page controller, bound to the top.
module sdram_page_ctrl_chk
    import sdpc_pkg::*;
#(
    parameter int CS_W   = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_no_ibank_ilv,
    input logic              req_ready,
    input logic              busy,
    input logic [2:0]        cmd_op,
    input logic [CS_W-1:0]   cmd_cs,
    input logic [BANK_W-1:0] dev_bank,
    input logic [ROW_W-1:0]  dev_addr
);

    // R10: completion coincides with a column command.
    p_ready_with_col_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd_op == OP_RD || cmd_op == OP_WR));

    // R10: completion lasts one cycle.
    p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R10: busy drops only right after completion.
    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(req_ready));

    // R11: idle cycles carry no command and a zero address.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd_op == OP_NOP && dev_addr == '0));

    // R11: precharge drives a zero address.
    p_pre_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PRE) |-> (dev_addr == '0));

    // R6: a precharge right after an activate closes a different bank.
    p_overlap_other_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PRE && $past(cmd_op) == OP_ACT) |->
            ($past(dev_bank) != dev_bank || $past(cmd_cs) != cmd_cs));

    // R7: with same-device overlap disabled, an overlap crosses chip selects.
    p_no_ibank_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PRE && $past(cmd_op) == OP_ACT && cfg_no_ibank_ilv) |->
            ($past(cmd_cs) != cmd_cs));

endmodule

bind sdram_page_ctrl sdram_page_ctrl_chk #(
    .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_no_ibank_ilv(cfg_no_ibank_ilv),
    .req_ready(req_ready), .busy(busy), .cmd_op(cmd_op), .cmd_cs(cmd_cs),
    .dev_bank(dev_bank), .dev_addr(dev_addr)
);

// File: tb/sdram_page_ctrl_tb_top.sv
// Bench: behavioural model of the command sequence, compared on every cycle.
module sdram_page_ctrl_tb_top;

    localparam int ADDR_W = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_page_map = 1'b1;
    logic        cfg_no_ibank_ilv = 1'b0;
    logic [3:0]  cfg_col_bits = 4'd8;
    logic [3:0]  cfg_trcd = 4'd3;
    logic [3:0]  cfg_trp = 4'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic [0:0]  req_cs = '0;
    logic        req_write = 1'b0;
    logic        busy, cmd_valid;
    logic [2:0]  cmd_op;
    logic [0:0]  cmd_cs;
    logic [1:0]  dev_bank;
    logic [11:0] dev_addr;

    sdram_page_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_page_map(cfg_page_map),
        .cfg_no_ibank_ilv(cfg_no_ibank_ilv), .cfg_col_bits(cfg_col_bits),
        .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_cs(req_cs),
        .req_write(req_write), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_cs(cmd_cs), .dev_bank(dev_bank), .dev_addr(dev_addr)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int    q_op[$], q_cs[$], q_bank[$], q_addr[$], q_rdy[$];
    string q_tag[$];

    bit m_open = 0;
    int m_cs = 0, m_bank = 0, m_row = 0;

    task automatic push(int op, int cs, int bank, int addr, int rdy, string tag);
        q_op.push_back(op); q_cs.push_back(cs); q_bank.push_back(bank);
        q_addr.push_back(addr); q_rdy.push_back(rdy); q_tag.push_back(tag);
    endtask

    task automatic push_nops(int n, string tag);
        for (int i = 0; i < n; i++) push(0, 0, 0, 0, 0, tag);
    endtask

    // Model: compute the expected command stream of one request.
    task automatic model_req(int addr, int cs, bit wr, string tag);
        int cb, bank, row, col, colop;
        cb  = int'(cfg_col_bits);
        col = addr & ((1 << cb) - 1);
        if (cfg_page_map) begin
            bank = (addr >> cb) & 3;
            row  = (addr >> (cb + 2)) & 12'hfff;
        end else begin
            bank = (addr >> (ADDR_W - 2)) & 3;
            row  = (addr >> cb) & 12'hfff;
        end
        colop = wr ? 4 : 3;
        if (m_open && m_cs == cs && m_bank == bank && m_row == row) begin
            push(colop, cs, bank, col, 1, tag);
        end else if (m_open && m_cs == cs && m_bank == bank) begin
            push(2, cs, bank, 0, 0, tag);
            push_nops(int'(cfg_trp) - 1, tag);
            push(1, cs, bank, row, 0, tag);
            push_nops(int'(cfg_trcd) - 1, tag);
            push(colop, cs, bank, col, 1, tag);
        end else if (m_open && (m_cs != cs || !cfg_no_ibank_ilv)) begin
            push(1, cs, bank, row, 0, tag);
            push(2, m_cs, m_bank, 0, 0, tag);
            push_nops(int'(cfg_trcd) - 2, tag);
            push(colop, cs, bank, col, 1, tag);
        end else if (m_open) begin
            push(2, m_cs, m_bank, 0, 0, tag);
            push_nops(int'(cfg_trp) - 1, tag);
            push(1, cs, bank, row, 0, tag);
            push_nops(int'(cfg_trcd) - 1, tag);
            push(colop, cs, bank, col, 1, tag);
        end else begin
            push(1, cs, bank, row, 0, tag);
            push_nops(int'(cfg_trcd) - 1, tag);
            push(colop, cs, bank, col, 1, tag);
        end
        m_open = 1; m_cs = cs; m_bank = bank; m_row = row;
    endtask

    // One cycle: sample away from the edge and compare with the model.
    task automatic step(string idle_tag);
        int eop, ecs, ebank, eaddr, erdy, ebusy;
        string tag;
        @(negedge clk);
        cyc++;
        if (q_op.size() > 0) begin
            eop = q_op.pop_front(); ecs = q_cs.pop_front(); ebank = q_bank.pop_front();
            eaddr = q_addr.pop_front(); erdy = q_rdy.pop_front(); tag = q_tag.pop_front();
            ebusy = 1;
        end else begin
            eop = 0; ecs = 0; ebank = 0; eaddr = 0; erdy = 0; ebusy = 0; tag = idle_tag;
        end
        checks++;
        if (int'(cmd_op) != eop || int'(cmd_cs) != ecs || int'(dev_bank) != ebank ||
            int'(dev_addr) != eaddr || int'(req_ready) != erdy || int'(busy) != ebusy ||
            cmd_valid != (eop != 0)) begin
            errors++;
            $display("FAIL %s (fields R11) cycle %0d: op/cs/bank/addr/rdy/busy act %0d/%0d/%0d/%0h/%0d/%0d exp %0d/%0d/%0d/%0h/%0d/%0d",
                     tag, cyc, cmd_op, cmd_cs, dev_bank, dev_addr, req_ready, busy,
                     eop, ecs, ebank, eaddr, erdy, ebusy);
        end
    endtask

    task automatic run_req(int addr, int cs, bit wr, string tag);
        req_addr  = 22'(addr);
        req_cs    = 1'(cs);
        req_write = wr;
        req_valid = 1'b1;
        model_req(addr, cs, wr, tag);
        do step(tag); while (q_op.size() > 0);
        req_valid = 1'b0;
        step("R10");
    endtask

    function automatic int pg(int row, int bank, int col);
        return (row << (int'(cfg_col_bits) + 2)) | (bank << int'(cfg_col_bits)) | col;
    endfunction

    function automatic int bk(int row, int bank, int col);
        return (bank << (ADDR_W - 2)) | (row << int'(cfg_col_bits)) | col;
    endfunction

    initial begin
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1'b1;
        step("R1");
        step("R1");
        // Page-based mapping, col 8, trcd 3, trp 2.
        run_req(pg(5, 1, 8'h12), 0, 1'b0, "R9");
        run_req(pg(5, 1, 8'h34), 0, 1'b0, "R4");
        run_req(pg(5, 1, 8'h35), 0, 1'b1, "R4");
        run_req(pg(5, 1, 8'h35) + 256, 0, 1'b1, "R6_R2");
        run_req(pg(9, 2, 8'h01), 0, 1'b0, "R5");
        cfg_no_ibank_ilv = 1'b1;
        run_req(pg(9, 3, 8'h02), 0, 1'b0, "R7");
        run_req(pg(9, 3, 8'h03), 1, 1'b1, "R8");
        // Minimum delays.
        cfg_no_ibank_ilv = 1'b0;
        cfg_trcd = 4'd2;
        cfg_trp  = 4'd1;
        run_req(pg(10, 3, 8'h04), 1, 1'b0, "R5");
        run_req(pg(10, 0, 8'h05), 1, 1'b1, "R6");
        // Bank-based mapping, col 6.
        cfg_page_map = 1'b0;
        cfg_col_bits = 4'd6;
        run_req(bk(12'h123, 2, 5), 1, 1'b0, "R3");
        run_req(bk(12'h123, 2, 6), 1, 1'b1, "R3");
        run_req(bk(12'h123, 2, 63) + 1, 1, 1'b0, "R3");
        run_req(bk(12'h7, 3, 1), 0, 1'b0, "R3");
        // Page-based with col 6: next page moves to the next bank.
        cfg_page_map = 1'b1;
        run_req(pg(12'h40, 0, 6'h3f), 0, 1'b1, "R2");
        run_req(pg(12'h40, 0, 6'h3f) + 1, 0, 1'b0, "R2");
        cfg_trcd = 4'd5;
        cfg_trp  = 4'd4;
        run_req(pg(12'h41, 1, 0), 0, 1'b0, "R5");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule